// File: doc/BRIEF.md
# Raster Line Cycle and Access Sequencer

This block lays out the timing of one raster line for a video controller that shares its memory bus with a CPU. It runs from the pixel clock, divides it by eight to produce bus cycles, and numbers those cycles 1 to 63 before starting again. Each bus cycle is split into two halves. The video side owns the bus in the first half and the CPU owns it in the second half.

The block has four outputs that a line-level controller uses. The first is a beam X coordinate that moves forward every half cycle and wraps once per line. The second is a code that names the memory access the video side makes in the current cycle: an idle read, a sprite pointer read tagged with its sprite number, a DRAM refresh, or a graphics read. The third is a flag that is high while the visible display window is open. The fourth is a pulse that covers the last cycle of the line, so that a line counter outside the block can advance on it.

Top module: `raster_line_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs show cycle 1, phase 0 and X coordinate 0x194. The access code is sprite pointer (1) with index 3, the display flag is low and the end-of-line pulse is low.
- R2: `cyc_o` holds each value for 8 clocks. It counts up by one after each hold and returns from 63 to 1.
- R3: `phase_o` is 0 for the first 4 clocks of each cycle, when the video side owns the bus. It is 1 for the last 4 clocks, when the CPU owns the bus.
- R4: `xpos_o` changes only at half-cycle boundaries. It goes up by 4 each time, except that 0x1F4 is followed by 0x000. The X wrap falls in the second half of cycle 13.
- R5: `xpos_o` is 0x18C in the first half of cycle 63 and 0x194 in the first half of cycle 1.
- R6: `acc_o` is 1 (sprite pointer) on the following cycles, with `spr_o` giving the sprite number:
  - cycle 58 → 0, cycle 60 → 1, cycle 62 → 2
  - cycle 1 → 3, cycle 3 → 4, cycle 5 → 5, cycle 7 → 6, cycle 9 → 7
- R7: `acc_o` is 2 (refresh) on cycles 11 to 15.
- R8: `acc_o` is 3 (graphics) on cycles 16 to 55. `disp_o` is high on exactly these cycles.
- R9: `acc_o` is 0 (idle) on cycles 2, 4, 6, 8, 10, 56, 57, 59, 61 and 63. `spr_o` is 0 whenever `acc_o` is not 1.
- R10: `eol_o` is high for all 8 clocks of cycle 63 and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, eight clocks per bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_o | output | 6 | Current bus cycle, 1 to 63 |
| phase_o | output | 1 | Bus half: 0 = video side, 1 = CPU |
| xpos_o | output | 9 | Beam X coordinate |
| acc_o | output | 3 | Video access code: 0 idle, 1 sprite pointer, 2 refresh, 3 graphics |
| spr_o | output | 3 | Sprite number for a sprite pointer access, otherwise 0 |
| disp_o | output | 1 | Display window open |
| eol_o | output | 1 | Last cycle of the line |

## Verification
The X wrap and the refresh slot overlap: the coordinate goes from 0x1F4 to 0x000 halfway through cycle 13, which is a refresh cycle. A dedicated scenario runs the line up to the last clock before that half-cycle boundary. It checks the coordinate and the refresh code there, then advances one clock and checks both again. A second overlap is the line turnover, where the end-of-line pulse, the idle slot and the cycle counter's return to 1 all meet. This overlap is judged on every clock of two whole lines against a model in the bench, and again after a reset asserted in the middle of a line.

// File: rtl/raster_line_pkg.sv
package raster_line_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE = 3'd0,
    ACC_SPTR = 3'd1,
    ACC_REFR = 3'd2,
    ACC_GFX  = 3'd3
  } acc_e;
endpackage

// File: rtl/raster_timebase.sv
module raster_timebase #(
  parameter int PIX_PER_CYC  = 8,
  parameter int CYC_PER_LINE = 63,
  localparam int PIX_W = $clog2(PIX_PER_CYC),
  localparam int CYC_W = $clog2(CYC_PER_LINE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PIX_W-1:0] pix_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             half_o,
  output logic             cyc_end_o
);
  localparam int HALF = PIX_PER_CYC / 2;

  logic [PIX_W-1:0] pix_q;
  logic [CYC_W-1:0] cyc_q;
  logic             last_pix;

  assign last_pix = (pix_q == PIX_W'(PIX_PER_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      cyc_q <= CYC_W'(1);
    end else begin
      pix_q <= last_pix ? '0 : pix_q + PIX_W'(1);
      if (last_pix) begin
        cyc_q <= (cyc_q == CYC_W'(CYC_PER_LINE)) ? CYC_W'(1) : cyc_q + CYC_W'(1);
      end
    end
  end

  assign pix_o     = pix_q;
  assign cyc_o     = cyc_q;
  assign half_o    = (pix_q >= PIX_W'(HALF));
  // marks the last clock of each half, where the beam steps
  assign cyc_end_o = last_pix || (pix_q == PIX_W'(HALF - 1));
endmodule

// File: rtl/raster_xbeam.sv
module raster_xbeam #(
  parameter int PIX_PER_CYC = 8,
  parameter int X_FIRST     = 'h194,
  parameter int X_LAST      = 'h1F4,
  localparam int X_W    = $clog2(X_LAST + 1),
  localparam int X_STEP = PIX_PER_CYC / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  output logic [X_W-1:0] x_o
);
  logic [X_W-1:0] x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= X_W'(X_FIRST);
    end else if (step_i) begin
      x_q <= (x_q == X_W'(X_LAST)) ? '0 : x_q + X_W'(X_STEP);
    end
  end

  assign x_o = x_q;
endmodule

// File: rtl/raster_slot_dec.sv
module raster_slot_dec
  import raster_line_pkg::*;
#(
  parameter int CYC_PER_LINE = 63,
  parameter int SPR_NUM      = 8,
  parameter int SPR_BASE     = 58,
  parameter int SPR_GAP      = 2,
  parameter int REF_FIRST    = 11,
  parameter int REF_LAST     = 15,
  parameter int GFX_FIRST    = 16,
  parameter int GFX_LAST     = 55,
  localparam int CYC_W = $clog2(CYC_PER_LINE + 1),
  localparam int SPR_W = $clog2(SPR_NUM)
) (
  input  logic [CYC_W-1:0] cyc_i,
  output acc_e             acc_o,
  output logic [SPR_W-1:0] spr_o
);
  logic [SPR_NUM-1:0] hit;

  for (genvar s = 0; s < SPR_NUM; s++) begin : g_spr
    // pointer slots start at SPR_BASE and run over the line end
    localparam int SLOT = ((SPR_BASE - 1 + SPR_GAP * s) % CYC_PER_LINE) + 1;
    assign hit[s] = (cyc_i == CYC_W'(SLOT));
  end

  always_comb begin
    spr_o = '0;
    for (int s = 0; s < SPR_NUM; s++) begin
      if (hit[s]) spr_o = SPR_W'(s);
    end
    if (|hit) begin
      acc_o = ACC_SPTR;
    end else if (cyc_i >= CYC_W'(REF_FIRST) && cyc_i <= CYC_W'(REF_LAST)) begin
      acc_o = ACC_REFR;
    end else if (cyc_i >= CYC_W'(GFX_FIRST) && cyc_i <= CYC_W'(GFX_LAST)) begin
      acc_o = ACC_GFX;
    end else begin
      acc_o = ACC_IDLE;
    end
  end
endmodule

// File: rtl/raster_win.sv
module raster_win #(
  parameter int CYC_PER_LINE = 63,
  parameter int WIN_FIRST    = 16,
  parameter int WIN_LAST     = 55,
  localparam int CYC_W = $clog2(CYC_PER_LINE + 1)
) (
  input  logic [CYC_W-1:0] cyc_i,
  output logic             disp_o,
  output logic             eol_o
);
  assign disp_o = (cyc_i >= CYC_W'(WIN_FIRST)) && (cyc_i <= CYC_W'(WIN_LAST));
  assign eol_o  = (cyc_i == CYC_W'(CYC_PER_LINE));
endmodule

// File: rtl/raster_line_seq.sv
module raster_line_seq
  import raster_line_pkg::*;
#(
  parameter int PIX_PER_CYC  = 8,
  parameter int CYC_PER_LINE = 63,
  parameter int X_FIRST      = 'h194,
  parameter int X_LAST       = 'h1F4,
  parameter int SPR_NUM      = 8,
  parameter int SPR_BASE     = 58,
  parameter int REF_FIRST    = 11,
  parameter int REF_LAST     = 15,
  parameter int GFX_FIRST    = 16,
  parameter int GFX_LAST     = 55,
  localparam int CYC_W = $clog2(CYC_PER_LINE + 1),
  localparam int X_W   = $clog2(X_LAST + 1),
  localparam int SPR_W = $clog2(SPR_NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CYC_W-1:0] cyc_o,
  output logic             phase_o,
  output logic [X_W-1:0]   xpos_o,
  output logic [2:0]       acc_o,
  output logic [SPR_W-1:0] spr_o,
  output logic             disp_o,
  output logic             eol_o
);
  localparam int PIX_W = $clog2(PIX_PER_CYC);

  logic [PIX_W-1:0] pix;
  logic             half_step;
  acc_e             acc;

  raster_timebase #(
    .PIX_PER_CYC (PIX_PER_CYC),
    .CYC_PER_LINE(CYC_PER_LINE)
  ) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_o    (pix),
    .cyc_o    (cyc_o),
    .half_o   (phase_o),
    .cyc_end_o(half_step)
  );

  raster_xbeam #(
    .PIX_PER_CYC(PIX_PER_CYC),
    .X_FIRST    (X_FIRST),
    .X_LAST     (X_LAST)
  ) u_xb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(half_step),
    .x_o   (xpos_o)
  );

  raster_slot_dec #(
    .CYC_PER_LINE(CYC_PER_LINE),
    .SPR_NUM     (SPR_NUM),
    .SPR_BASE    (SPR_BASE),
    .SPR_GAP     (2),
    .REF_FIRST   (REF_FIRST),
    .REF_LAST    (REF_LAST),
    .GFX_FIRST   (GFX_FIRST),
    .GFX_LAST    (GFX_LAST)
  ) u_dec (
    .cyc_i(cyc_o),
    .acc_o(acc),
    .spr_o(spr_o)
  );

  raster_win #(
    .CYC_PER_LINE(CYC_PER_LINE),
    .WIN_FIRST   (GFX_FIRST),
    .WIN_LAST    (GFX_LAST)
  ) u_win (
    .cyc_i (cyc_o),
    .disp_o(disp_o),
    .eol_o (eol_o)
  );

  assign acc_o = 3'(acc);

  logic unused_pix;
  assign unused_pix = ^pix;
endmodule

// File: rtl/raster_line_seq_chk.sv
module raster_line_seq_chk #(
  parameter int CYC_PER_LINE = 63,
  parameter int X_LAST       = 'h1F4,
  parameter int CYC_W        = 6,
  parameter int X_W          = 9,
  parameter int SPR_W        = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CYC_W-1:0] cyc_o,
  input logic             phase_o,
  input logic [X_W-1:0]   xpos_o,
  input logic [2:0]       acc_o,
  input logic [SPR_W-1:0] spr_o,
  input logic             disp_o,
  input logic             eol_o
);
  assert_cyc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o != $past(cyc_o)) |->
      (cyc_o == (($past(cyc_o) == CYC_W'(CYC_PER_LINE)) ? CYC_W'(1) : $past(cyc_o) + CYC_W'(1))));

  assert_cyc_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o != $past(cyc_o)) |-> ($past(phase_o) && !phase_o));

  assert_phase_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o) |-> $stable(cyc_o));

  assert_x_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xpos_o != $past(xpos_o)) |->
      (xpos_o == (($past(xpos_o) == X_W'(X_LAST)) ? '0 : $past(xpos_o) + X_W'(4))));

  assert_x_on_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xpos_o != $past(xpos_o)) |-> (phase_o != $past(phase_o)));

  assert_refresh_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o == 3'd2) |-> (cyc_o >= CYC_W'(11) && cyc_o <= CYC_W'(15)));

  assert_disp_gfx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_o == (acc_o == 3'd3));

  assert_idx_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != 3'd1) |-> (spr_o == '0));

  assert_eol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> (cyc_o == CYC_W'(CYC_PER_LINE) && acc_o == 3'd0));
endmodule

bind raster_line_seq raster_line_seq_chk #(
  .CYC_PER_LINE(CYC_PER_LINE),
  .X_LAST      (X_LAST),
  .CYC_W       (CYC_W),
  .X_W         (X_W),
  .SPR_W       (SPR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cyc_o  (cyc_o),
  .phase_o(phase_o),
  .xpos_o (xpos_o),
  .acc_o  (acc_o),
  .spr_o  (spr_o),
  .disp_o (disp_o),
  .eol_o  (eol_o)
);

// File: tb/raster_line_seq_tb.sv
module raster_line_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] cyc_o;
  logic       phase_o;
  logic [8:0] xpos_o;
  logic [2:0] acc_o;
  logic [2:0] spr_o;
  logic       disp_o;
  logic       eol_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cyc_m = 1;
  int pix_m = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  raster_line_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_o(cyc_o), .phase_o(phase_o),
    .xpos_o(xpos_o), .acc_o(acc_o), .spr_o(spr_o), .disp_o(disp_o), .eol_o(eol_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d pix=%0d act=0x%0h exp=0x%0h", req, cyc_m, pix_m, act, exp);
    end
  endtask

  function automatic int exp_x(int c, int p);
    int idx = (c - 1) * 2 + ((p >= 4) ? 1 : 0);
    return (404 + 4 * idx) % 504;
  endfunction

  function automatic int exp_acc(int c);
    case (c)
      58, 60, 62, 1, 3, 5, 7, 9: return 1;
      11, 12, 13, 14, 15:        return 2;
      default: return (c >= 16 && c <= 55) ? 3 : 0;
    endcase
  endfunction

  function automatic int exp_spr(int c);
    case (c)
      58: return 0;  60: return 1;  62: return 2;
      1:  return 3;  3:  return 4;  5:  return 5;  7: return 6;  9: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    int ea = exp_acc(cyc_m);
    chk(cyc_o == 6'(cyc_m), "R2", cyc_o, cyc_m);
    chk(phase_o == (pix_m >= 4), "R3", phase_o, pix_m >= 4);
    if (pix_m < 4 && (cyc_m == 63 || cyc_m == 1))
      chk(xpos_o == 9'(exp_x(cyc_m, pix_m)), "R5", xpos_o, exp_x(cyc_m, pix_m));
    else
      chk(xpos_o == 9'(exp_x(cyc_m, pix_m)), "R4", xpos_o, exp_x(cyc_m, pix_m));
    case (ea)
      1: chk(acc_o == 3'd1, "R6", acc_o, ea);
      2: chk(acc_o == 3'd2, "R7", acc_o, ea);
      3: chk(acc_o == 3'd3, "R8", acc_o, ea);
      default: chk(acc_o == 3'd0, "R9", acc_o, ea);
    endcase
    chk(spr_o == 3'(exp_spr(cyc_m)), (ea == 1) ? "R6" : "R9", spr_o, exp_spr(cyc_m));
    chk(disp_o == (cyc_m >= 16 && cyc_m <= 55), "R8", disp_o, cyc_m >= 16 && cyc_m <= 55);
    chk(eol_o == (cyc_m == 63), "R10", eol_o, cyc_m == 63);
  endtask

  task automatic step();
    @(posedge clk_i);
    if (pix_m == 7) begin
      pix_m = 0;
      cyc_m = (cyc_m == 63) ? 1 : cyc_m + 1;
    end else begin
      pix_m++;
    end
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    cyc_m = 1; pix_m = 0;
    chk(cyc_o == 6'd1, "R1", cyc_o, 1);
    chk(phase_o == 1'b0, "R1", phase_o, 0);
    chk(xpos_o == 9'h194, "R1", xpos_o, 'h194);
    chk(acc_o == 3'd1 && spr_o == 3'd3, "R1", {acc_o, spr_o}, {3'd1, 3'd3});
    chk(!disp_o && !eol_o, "R1", {disp_o, eol_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_two_lines();
    compare_all();
    for (int i = 0; i < 2 * 63 * 8; i++) begin
      step();
      compare_all();
    end
  endtask

  // X wrap lands inside refresh cycle 13
  task automatic t_wrap_in_refresh();
    while (!(cyc_m == 13 && pix_m == 3)) step();
    chk(xpos_o == 9'h1F4, "R4", xpos_o, 'h1F4);
    chk(acc_o == 3'd2, "R7", acc_o, 2);
    step();
    chk(xpos_o == 9'h000, "R4", xpos_o, 0);
    chk(acc_o == 3'd2, "R7", acc_o, 2);
    chk(phase_o == 1'b1, "R3", phase_o, 1);
  endtask

  task automatic t_mid_reset();
    while (!(cyc_m == 40 && pix_m == 5)) step();
    compare_all();
    rst_ni = 1'b0;
    #1;
    cyc_m = 1; pix_m = 0;
    chk(cyc_o == 6'd1, "R1", cyc_o, 1);
    chk(xpos_o == 9'h194, "R1", xpos_o, 'h194);
    chk(phase_o == 1'b0, "R1", phase_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare_all();
    for (int i = 0; i < 63 * 8 + 16; i++) begin
      step();
      compare_all();
    end
  endtask

  initial begin
    t_reset();
    t_two_lines();
    t_wrap_in_refresh();
    t_mid_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule